// File: doc/BRIEF.md
# Capture/Compare Timer

A 16-bit free-running timer that sits behind a small 8-bit register bus. A fixed power-of-two prescaler paces the counter. One capture input copies the counter into a pair of read-only bytes on a rising edge. Two compare channels each hold a 16-bit value. When the counter steps onto that value, the channel raises a status flag and toggles its output pin.

Software clears a compare flag with a two-step handshake. It first reads the status register while the flag is set, then reads or writes that channel's compare low byte. A disable bit in the status register freezes the prescaler and the counter and forces both outputs low. While the timer is disabled, every register can still be read and written, so software can reprogram the timer and reload the counter.

Register addresses (4-bit): 0 status/control, 1 capture high, 2 capture low, 3 compare-A high, 4 compare-A low, 5 compare-B high, 6 compare-B low, 7 counter high, 8 counter low. A read has its side effects on the clock edge where `bus_rd` is high, and `bus_rdata` shows the addressed register in that same cycle.

Top module: `cc_timer`

## Requirements
- R1: After reset the status register reads 00h, both compare registers read 80h (high byte) and 00h (low byte), the counter reads 0000h and both outputs are low.
- R2: While enabled, the counter advances by one every 2^PRESC_LOG2 clocks and wraps from FFFFh to 0000h.
- R3: Writing the counter high byte (address 7) stages a value. A following write of the counter low byte (address 8) loads the staged byte and the written byte as one 16-bit value, and clears the prescaler.
- R4: On the first clock where `cap_in` is high after being low, the counter value held before that edge is copied into the capture bytes (high at address 1, low at address 2).
- R5: Reading the capture high byte freezes a copy of the low byte. The next read of the capture low byte returns that copy, even if a capture occurred in between.
- R6: When the counter steps onto a channel's compare value, that channel's flag sets (compare-A at status bit 4, compare-B at status bit 3) and its output toggles.
- R7: Writing a compare high byte stops that channel from matching until its low byte is written.
- R8: A compare flag clears only when a status read that saw the flag set is followed by a read or write of that channel's compare low byte. Accessing the low byte without that prior read leaves the flag set.
- R9: With status bit 2 at 1, the prescaler and counter hold their values and both outputs are low. Clearing the bit restores each output's toggle state.
- R10: While the timer is disabled, the compare registers and the counter can still be written and read back.
- R11: Status bits 7..5 and 1..0 read as zero, and writes to the status register change only bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; side effects occur on this clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| cap_in | input | 1 | Capture input, rising-edge sensitive |
| cmp_a_out | output | 1 | Compare-A output pin |
| cmp_b_out | output | 1 | Compare-B output pin |

## Verification
The bench builds the timer with PRESC_LOG2 = 1, so the counter steps every second clock. This puts wrap-around, match timing and prescaler alignment after a counter load within a few cycles of an exact expected value. Together with counter loads, it lets randomized load values and wait lengths reach any part of the 16-bit range, including the wrap, without long runs.

// File: rtl/cc_timer.sv
module cc_timer #(
  parameter int          PRESC_LOG2 = 2,
  parameter logic [15:0] CMP_RST    = 16'h8000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] bus_addr,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       cap_in,
  output logic       cmp_a_out,
  output logic       cmp_b_out
);
  localparam int CW = 16;
  localparam int NCH = 2;
  localparam logic [3:0] A_STAT = 4'd0, A_CAPH = 4'd1, A_CAPL = 4'd2,
                         A_CNTH = 4'd7, A_CNTL = 4'd8;

  logic          dis;
  logic [CW-1:0] cnt;
  logic [CW-1:0] cnt_nxt;
  logic [7:0]    cnt_stage;
  logic          tick;
  logic          cnt_load;
  logic          st_rd;
  logic [NCH-1:0] ocf, arm, tog, lo_acc;
  logic [NCH-1:0][CW-1:0] cmp_v;
  logic          cap_prev;
  logic [CW-1:0] cap_q;
  logic [7:0]    lo_hold;
  logic          hold_v;

  assign cnt_nxt  = cnt + 16'd1;
  assign cnt_load = bus_wr && bus_addr == A_CNTL;
  assign st_rd    = bus_rd && bus_addr == A_STAT;

  generate
    if (PRESC_LOG2 == 0) begin : g_nopre
      assign tick = !dis && !cnt_load;
    end else begin : g_pre
      logic [PRESC_LOG2-1:0] pre_q;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)        pre_q <= '0;
        else if (cnt_load) pre_q <= '0;
        else if (!dis)     pre_q <= pre_q + 1'b1;
      assign tick = !dis && !cnt_load && (&pre_q);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      dis       <= 1'b0;
      cnt       <= '0;
      cnt_stage <= '0;
    end else begin
      if (bus_wr && bus_addr == A_STAT) dis <= bus_wdata[2];
      if (bus_wr && bus_addr == A_CNTH) cnt_stage <= bus_wdata;
      if (cnt_load)  cnt <= {cnt_stage, bus_wdata};
      else if (tick) cnt <= cnt_nxt;
    end

  generate
    for (genvar k = 0; k < NCH; k++) begin : g_ch
      localparam logic [3:0] A_HI = 4'(3 + 2*k);
      localparam logic [3:0] A_LO = 4'(4 + 2*k);
      logic [CW-1:0] cmp_q;
      logic flag_q, seen_q, arm_q, tog_q, hit, lo_hit;

      assign lo_hit = (bus_rd || bus_wr) && bus_addr == A_LO;
      assign hit    = tick && arm_q && cnt_nxt == cmp_q;

      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          cmp_q  <= CMP_RST;
          flag_q <= 1'b0;
          seen_q <= 1'b0;
          arm_q  <= 1'b1;
          tog_q  <= 1'b0;
        end else begin
          if (bus_wr && bus_addr == A_HI) begin
            cmp_q[15:8] <= bus_wdata;
            arm_q       <= 1'b0;
          end
          if (bus_wr && bus_addr == A_LO) begin
            cmp_q[7:0] <= bus_wdata;
            arm_q      <= 1'b1;
          end
          flag_q <= hit || (flag_q && !(seen_q && lo_hit));
          if (st_rd)       seen_q <= flag_q;
          else if (lo_hit) seen_q <= 1'b0;
          tog_q <= tog_q ^ hit;
        end

      assign ocf[k]    = flag_q;
      assign arm[k]    = arm_q;
      assign tog[k]    = tog_q;
      assign lo_acc[k] = lo_hit;
      assign cmp_v[k]  = cmp_q;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cap_prev <= 1'b1;
      cap_q    <= '0;
      lo_hold  <= '0;
      hold_v   <= 1'b0;
    end else begin
      cap_prev <= cap_in;
      if (cap_in && !cap_prev) cap_q <= cnt;
      if (bus_rd && bus_addr == A_CAPH) begin
        lo_hold <= cap_q[7:0];
        hold_v  <= 1'b1;
      end else if (bus_rd && bus_addr == A_CAPL) begin
        hold_v <= 1'b0;
      end
    end

  assign cmp_a_out = tog[0] && !dis;
  assign cmp_b_out = tog[1] && !dis;

  always_comb begin
    case (bus_addr)
      A_STAT:  bus_rdata = {3'b000, ocf[0], ocf[1], dis, 2'b00};
      A_CAPH:  bus_rdata = cap_q[15:8];
      A_CAPL:  bus_rdata = hold_v ? lo_hold : cap_q[7:0];
      4'd3:    bus_rdata = cmp_v[0][15:8];
      4'd4:    bus_rdata = cmp_v[0][7:0];
      4'd5:    bus_rdata = cmp_v[1][15:8];
      4'd6:    bus_rdata = cmp_v[1][7:0];
      A_CNTH:  bus_rdata = cnt[15:8];
      A_CNTL:  bus_rdata = cnt[7:0];
      default: bus_rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/cc_timer_chk.sv
module cc_timer_chk (
  input logic            clk,
  input logic            rst_n,
  input logic            dis,
  input logic [15:0]     cnt,
  input logic            cnt_load,
  input logic [1:0]      ocf,
  input logic [1:0]      arm,
  input logic [1:0]      lo_acc,
  input logic [1:0][15:0] cmp_v,
  input logic            cmp_a_out,
  input logic            cmp_b_out
);
  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != $past(cnt)) && !$past(cnt_load) |-> cnt == $past(cnt) + 16'd1);

  assert_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(dis) && !$past(cnt_load) |-> $stable(cnt));

  assert_flag_a_at_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ocf[0]) |-> cnt == cmp_v[0]);

  assert_flag_b_at_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ocf[1]) |-> cnt == cmp_v[1]);

  assert_out_on_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_a_out != $past(cmp_a_out)) && !dis && !$past(dis) |-> cnt != $past(cnt));

  assert_no_match_unarmed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(arm[0]) |-> !$rose(ocf[0]));

  assert_clear_a_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ocf[0]) |-> $past(lo_acc[0]));

  assert_clear_b_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ocf[1]) |-> $past(lo_acc[1]));

  assert_out_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(dis) && dis |-> !cmp_b_out);
endmodule

bind cc_timer cc_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .dis(dis), .cnt(cnt), .cnt_load(cnt_load),
  .ocf(ocf), .arm(arm), .lo_acc(lo_acc), .cmp_v(cmp_v),
  .cmp_a_out(cmp_a_out), .cmp_b_out(cmp_b_out)
);

// File: tb/cc_timer_bench.sv
module cc_timer_bench;
  localparam int CLK_P = 10;
  localparam int PL = 1;
  localparam logic [3:0] STAT = 0, CAPH = 1, CAPL = 2, AH = 3, AL = 4,
                         BH = 5, BL = 6, CNTH = 7, CNTL = 8;

  logic clk = 0, rst_n = 0;
  logic [3:0] bus_addr = 0;
  logic bus_wr = 0, bus_rd = 0, cap_in = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic cmp_a_out, cmp_b_out;
  int total = 0, bad = 0;
  logic exp_ta = 0, exp_tb = 0;
  logic [7:0] d;

  always #(CLK_P/2) clk = ~clk;

  cc_timer #(.PRESC_LOG2(PL)) u_cc_timer (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cap_in(cap_in), .cmp_a_out(cmp_a_out), .cmp_b_out(cmp_b_out));

  function automatic logic [15:0] exp_cnt(logic [15:0] v, int k);
    return v + 16'(k >> PL);
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] v);
    bus_addr = a; bus_wdata = v; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [7:0] v);
    bus_addr = a; bus_rd = 1; #1 v = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic waitn(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(logic [15:0] v);
    wr(CNTH, v[15:8]); wr(CNTL, v[7:0]);
  endtask

  task automatic finish_up;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_up();
  end

  initial begin
    void'($urandom(32'h1f2e3d4c));
    waitn(3); rst_n = 1;
    // R1 reset state
    rd(CNTL, d); chk("R1 cnt lo", d, 8'h00);
    rd(STAT, d); chk("R1 status", d, 8'h00);
    rd(AH, d);   chk("R1 cmpA hi", d, 8'h80);
    rd(AL, d);   chk("R1 cmpA lo", d, 8'h00);
    rd(BH, d);   chk("R1 cmpB hi", d, 8'h80);
    rd(BL, d);   chk("R1 cmpB lo", d, 8'h00);
    chk("R1 outputs", {cmp_a_out, cmp_b_out}, 2'b00);

    // R3 load, R2 wrap
    load(16'hFFFE); waitn(4);
    rd(CNTL, d); chk("R2 wrap lo", d, 8'h00);
    rd(CNTH, d); chk("R2 wrap hi", d, 8'h00);
    load(16'h4321);
    rd(CNTH, d); chk("R3 load hi", d, 8'h43);
    rd(CNTL, d); chk("R3 load lo", d, 8'h21);

    // R4 capture
    load(16'h0100); waitn(5);
    cap_in = 1; @(negedge clk); cap_in = 0;
    rd(CAPH, d); chk("R4 cap hi", d, 8'h01);
    rd(CAPL, d); chk("R4 cap lo", d, 8'h02);

    // R5 coherent read
    load(16'h0200); waitn(3);
    cap_in = 1; @(negedge clk); cap_in = 0;
    rd(CAPH, d); chk("R5 cap hi", d, 8'h02);
    waitn(4);
    cap_in = 1; @(negedge clk); cap_in = 0;
    rd(CAPL, d); chk("R5 held lo", d, 8'h01);
    rd(CAPH, d); chk("R5 new hi", d, 8'h02);
    rd(CAPL, d); chk("R5 new lo", d, 8'h04);

    // R6 channel A match and R8 clear
    wr(AH, 8'h12); wr(AL, 8'h34);
    load(16'h1230); waitn(7);
    rd(STAT, d); chk("R6 before match", d, 8'h00);
    waitn(2);
    rd(STAT, d); chk("R6 flag A", d, 8'h10);
    exp_ta = ~exp_ta;
    chk("R6 out A", cmp_a_out, exp_ta);
    rd(AL, d); chk("R8 cmpA lo", d, 8'h34);
    rd(STAT, d); chk("R8 cleared A", d, 8'h00);

    // R6 channel B, R8 without prior status read
    wr(BH, 8'h20); wr(BL, 8'h00);
    load(16'h1FFD); waitn(10);
    exp_tb = ~exp_tb;
    chk("R6 out B", cmp_b_out, exp_tb);
    wr(BL, 8'h00);
    rd(STAT, d); chk("R8 flag kept B", d, 8'h08);
    wr(BL, 8'h00);
    rd(STAT, d); chk("R8 cleared B", d, 8'h00);

    // R7 inhibit until low written
    wr(AH, 8'h30);
    load(16'h3030); waitn(12);
    rd(STAT, d); chk("R7 inhibited", d, 8'h00);
    chk("R7 out A held", cmp_a_out, exp_ta);
    wr(AL, 8'h34);
    load(16'h3030); waitn(12);
    rd(STAT, d); chk("R7 rearmed", d, 8'h10);
    exp_ta = ~exp_ta;
    chk("R7 out A", cmp_a_out, exp_ta);
    rd(AL, d);
    rd(STAT, d); chk("R8 cleared A again", d, 8'h00);

    // R11 reserved bits, R9 disable
    wr(STAT, 8'hFF);
    rd(STAT, d); chk("R11 status", d, 8'h04);
    rd(CNTL, d); waitn(10);
    begin
      logic [7:0] d2;
      rd(CNTL, d2); chk("R9 frozen", d2, d);
    end
    chk("R9 outputs low", {cmp_a_out, cmp_b_out}, 2'b00);

    // R10 access while disabled
    load(16'h55AA); waitn(6);
    rd(CNTH, d); chk("R10 cnt hi", d, 8'h55);
    rd(CNTL, d); chk("R10 cnt lo", d, 8'hAA);
    wr(BH, 8'h13); wr(BL, 8'h57);
    rd(BH, d); chk("R10 cmpB hi", d, 8'h13);
    rd(BL, d); chk("R10 cmpB lo", d, 8'h57);

    // R9 re-enable
    wr(STAT, 8'h00); waitn(4);
    rd(CNTL, d); chk("R9 resume", d, 8'hAC);
    chk("R9 out B restored", cmp_b_out, exp_tb);

    // R2 random loads and waits
    for (int i = 0; i < 40; i++) begin
      logic [15:0] v, e;
      int m;
      v = 16'($urandom);
      if (i < 4) v = 16'hFFF0 + 16'(i * 3);
      m = int'($urandom % 40);
      load(v); waitn(m);
      rd(CNTH, d); e = exp_cnt(v, m);
      chk("R2 rand hi", d, e[15:8]);
      rd(CNTL, d); e = exp_cnt(v, m + 1);
      chk("R2 rand lo", d, e[7:0]);
    end
    finish_up();
  end
endmodule